// File: doc/BRIEF.md
# Clock Mode and Stop Control

This block holds the clock-generation configuration of a chip and turns it into the control lines for the PLL, the crystal oscillator, the core clock source mux and the clock-output pin mux. Software writes a small configuration word through a simple write port and can read the whole word back. Two bits of the word select the PLL operating mode: bypass with the PLL running, bypass with the PLL powered down, or the multiplied PLL output as the core clock. The fourth combination of those two bits is illegal. A write that asks for it is dropped and a sticky error flag is raised.

A stop sequencer follows stop-mode entry and exit strobes. Entering stop leaves the PLL power state as programmed. The oscillator is gated only if the low-power-stop bit was set at the moment of entry. On exit the oscillator is re-enabled at once. The core clock stays on the oscillator until an oscillator-stable input is seen, and only then returns to the PLL if the PLL is enabled. A test bit decides whether the clock-output select field may route the prescaler output to the pin.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the configuration word reads 0, pll_en_o=0, pll_pd_o=0, osc_en_o=1, core_src_o=0 (oscillator) and cfg_err_o=0. The sequencer is in the run state.
- R2: With enable bit (bit 0) = 0 and power-down bit (bit 1) = 0, pll_en_o=0, pll_pd_o=0 and core_src_o=0.
- R3: With bit 0 = 1 and bit 1 = 0, pll_en_o=1 and, in the run state, core_src_o=1 (PLL output) on the cycle after the write.
- R4: With bit 0 = 0 and bit 1 = 1, pll_pd_o=1, pll_en_o=0 and core_src_o=0.
- R5: A write with bits 1:0 = 11 leaves the whole word unchanged and sets cfg_err_o. cfg_err_o then stays 1 until reset, and later legal writes do not clear it.
- R6: Entering stop does not change pll_en_o or pll_pd_o. While stopped, core_src_o=0.
- R7: If the low-power-stop bit (bit 2) is 1 when stop is entered, osc_en_o=0 from the next cycle until stop exit. If bit 2 is 0 at entry, osc_en_o stays 1. Writing bit 2 while stopped has no effect on osc_en_o.
- R8: On the cycle after a stop exit strobe, osc_en_o=1 and core_src_o=0. core_src_o stays 0 until osc_stable_i is sampled high. The sequencer is back in the run state on the following cycle.
- R9: clkout_req_i codes are 0 = core clock, 1 = oscillator, 2 = prescaler, 3 = pin off. clkout_sel_o copies the code, except that code 2 is granted only when the test bit (bit 3) is 1. Otherwise code 2 becomes 3. This path is combinational.
- R10: rd_data_o returns bits 3:0 of the word as stored, and every higher bit reads 0.
- R11: A stop entry strobe is ignored unless the sequencer is in the run state. A stop exit strobe is ignored unless it is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | REG_W | Configuration write data |
| rd_data_o | output | REG_W | Configuration read-back |
| stop_enter_i | input | 1 | Stop-mode entry strobe |
| stop_exit_i | input | 1 | Stop-mode exit strobe |
| osc_stable_i | input | 1 | Oscillator stable indication |
| clkout_req_i | input | 2 | Clock-output source request |
| pll_en_o | output | 1 | PLL output selected as clock source |
| pll_pd_o | output | 1 | PLL power-down |
| osc_en_o | output | 1 | Oscillator enable |
| core_src_o | output | 1 | Core clock source, 0 oscillator, 1 PLL |
| clkout_sel_o | output | 2 | Clock-output pin mux select |
| cfg_err_o | output | 1 | Sticky reserved-write error |

## Verification
A corrupted configuration word appears on rd_data_o and on the PLL lines on the cycle after the write that caused it. A sequencer stuck in the wrong state shows one cycle after the strobe. In that case osc_en_o stays low after exit, or core_src_o selects the PLL before osc_stable_i. A latched low-power-stop value that tracks the live bit shows up as soon as bit 2 is rewritten during stop. A dropped sticky flag shows up on the first legal write after a reserved one.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int unsigned BIT_PLL_EN = 0;
  localparam int unsigned BIT_PLL_PD = 1;
  localparam int unsigned BIT_LPS    = 2;
  localparam int unsigned BIT_TEST   = 3;
  localparam int unsigned CFG_BITS   = 4;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAKE = 2'd2
  } stop_st_e;

  typedef enum logic [1:0] {
    CO_CORE = 2'd0,
    CO_OSC  = 2'd1,
    CO_PSCL = 2'd2,
    CO_OFF  = 2'd3
  } clkout_e;

  localparam logic SRC_OSC = 1'b0;
  localparam logic SRC_PLL = 1'b1;
endpackage

// File: rtl/clk_cfg_reg.sv
module clk_cfg_reg
  import clk_ctrl_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             pll_en_o,
  output logic             pll_pd_o,
  output logic             lps_o,
  output logic             test_o,
  output logic             err_o
);
  localparam int unsigned PAD_W = REG_W - CFG_BITS;

  logic [CFG_BITS-1:0] cfg_q;
  logic                err_q;
  logic                reserved_req;

  assign reserved_req = wr_data_i[BIT_PLL_EN] & wr_data_i[BIT_PLL_PD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (wr_en_i) begin
      if (reserved_req) err_q <= 1'b1;
      else              cfg_q <= wr_data_i[CFG_BITS-1:0];
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data_o = {{PAD_W{1'b0}}, cfg_q};
    end else begin : g_nopad
      assign rd_data_o = cfg_q;
    end
  endgenerate

  assign pll_en_o = cfg_q[BIT_PLL_EN];
  assign pll_pd_o = cfg_q[BIT_PLL_PD];
  assign lps_o    = cfg_q[BIT_LPS];
  assign test_o   = cfg_q[BIT_TEST];
  assign err_o    = err_q;

  // R5: reserved request never alters stored word
  p_reserved_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reserved_req) |=> $stable(rd_data_o));
  p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_no_reserved_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pll_en_o && pll_pd_o));
endmodule

// File: rtl/clk_stop_seq.sv
module clk_stop_seq
  import clk_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_enter_i,
  input  logic stop_exit_i,
  input  logic osc_stable_i,
  input  logic lps_i,
  input  logic pll_en_i,
  output logic osc_en_o,
  output logic core_src_o
);
  stop_st_e st_q, st_d;
  logic     lps_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (stop_enter_i) st_d = ST_STOP;
      ST_STOP: if (stop_exit_i)  st_d = ST_WAKE;
      ST_WAKE: if (osc_stable_i) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      lps_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RUN && stop_enter_i) lps_q <= lps_i;  // latched at entry only
    end
  end

  assign osc_en_o   = !(st_q == ST_STOP && lps_q);
  assign core_src_o = (st_q == ST_RUN && pll_en_i) ? SRC_PLL : SRC_OSC;

  p_lps_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && stop_enter_i && lps_i) |=> !osc_en_o);
  p_keep_osc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && stop_enter_i && !lps_i) |=> osc_en_o);
  p_wake_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STOP && stop_exit_i) |=> (osc_en_o && core_src_o == SRC_OSC));
  p_src_pll_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_src_o == SRC_PLL) |-> pll_en_i);
endmodule

// File: rtl/clk_out_sel.sv
module clk_out_sel
  import clk_ctrl_pkg::*;
(
  input  logic [1:0] req_i,
  input  logic       test_i,
  output logic [1:0] sel_o
);
  always_comb begin
    sel_o = req_i;
    if (req_i == CO_PSCL && !test_i) sel_o = CO_OFF;
  end

  always_comb begin
    p_pscl_needs_test_r9: assert (!(sel_o == CO_PSCL) || test_i);
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_ctrl_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             stop_enter_i,
  input  logic             stop_exit_i,
  input  logic             osc_stable_i,
  input  logic [1:0]       clkout_req_i,
  output logic             pll_en_o,
  output logic             pll_pd_o,
  output logic             osc_en_o,
  output logic             core_src_o,
  output logic [1:0]       clkout_sel_o,
  output logic             cfg_err_o
);
  logic lps, test_en;

  clk_cfg_reg #(.REG_W(REG_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .pll_en_o  (pll_en_o),
    .pll_pd_o  (pll_pd_o),
    .lps_o     (lps),
    .test_o    (test_en),
    .err_o     (cfg_err_o)
  );

  clk_stop_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_enter_i (stop_enter_i),
    .stop_exit_i  (stop_exit_i),
    .osc_stable_i (osc_stable_i),
    .lps_i        (lps),
    .pll_en_i     (pll_en_o),
    .osc_en_o     (osc_en_o),
    .core_src_o   (core_src_o)
  );

  clk_out_sel i_out (
    .req_i  (clkout_req_i),
    .test_i (test_en),
    .sel_o  (clkout_sel_o)
  );

  // R6: stop entry leaves PLL lines untouched
  p_stop_pll_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_enter_i && !wr_en_i) |=> ($stable(pll_pd_o) && $stable(pll_en_o)));
endmodule

// File: tb/test_clk_mode_ctrl.sv
module test_clk_mode_ctrl;
  localparam int unsigned REG_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [REG_W-1:0] wr_data_i = '0;
  logic [REG_W-1:0] rd_data_o;
  logic             stop_enter_i = 1'b0;
  logic             stop_exit_i = 1'b0;
  logic             osc_stable_i = 1'b0;
  logic [1:0]       clkout_req_i = 2'd0;
  logic             pll_en_o, pll_pd_o, osc_en_o, core_src_o, cfg_err_o;
  logic [1:0]       clkout_sel_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  clk_mode_ctrl #(.REG_W(REG_W)) i_clk_mode_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
    .stop_enter_i, .stop_exit_i, .osc_stable_i, .clkout_req_i,
    .pll_en_o, .pll_pd_o, .osc_en_o, .core_src_o, .clkout_sel_o, .cfg_err_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [REG_W-1:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse_enter();
    stop_enter_i = 1'b1; tick(); stop_enter_i = 1'b0;
  endtask

  task automatic pulse_exit();
    stop_exit_i = 1'b1; tick(); stop_exit_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "rd_data", int'(rd_data_o), 0);
    chk("R1", "pll_en", int'(pll_en_o), 0);
    chk("R1", "pll_pd", int'(pll_pd_o), 0);
    chk("R1", "osc_en", int'(osc_en_o), 1);
    chk("R1", "core_src", int'(core_src_o), 0);
    chk("R1", "err", int'(cfg_err_o), 0);
  endtask

  task automatic t_modes();
    wr(8'h01);
    chk("R3", "pll_en", int'(pll_en_o), 1);
    chk("R3", "core_src", int'(core_src_o), 1);
    wr(8'h02);
    chk("R4", "pll_pd", int'(pll_pd_o), 1);
    chk("R4", "pll_en", int'(pll_en_o), 0);
    chk("R4", "core_src", int'(core_src_o), 0);
    wr(8'h00);
    chk("R2", "pll_pd", int'(pll_pd_o), 0);
    chk("R2", "pll_en", int'(pll_en_o), 0);
    chk("R2", "core_src", int'(core_src_o), 0);
  endtask

  task automatic t_reserved();
    wr(8'h01);
    wr(8'h03);
    chk("R5", "rd after reserved", int'(rd_data_o), 1);
    chk("R5", "err set", int'(cfg_err_o), 1);
    chk("R5", "core_src kept", int'(core_src_o), 1);
    wr(8'h02);
    chk("R5", "rd after legal", int'(rd_data_o), 2);
    chk("R5", "err sticky", int'(cfg_err_o), 1);
    wr(8'h00);
  endtask

  task automatic t_readback();
    wr(8'hFC);
    chk("R10", "rd upper zero", int'(rd_data_o), 8'h0C);
    wr(8'hF5);
    chk("R10", "rd pattern", int'(rd_data_o), 8'h05);
    wr(8'h00);
  endtask

  task automatic t_stop_keep_osc();
    wr(8'h01);
    pulse_enter();
    chk("R7", "osc kept lps=0", int'(osc_en_o), 1);
    chk("R6", "pll_pd in stop", int'(pll_pd_o), 0);
    chk("R6", "pll_en in stop", int'(pll_en_o), 1);
    chk("R6", "core_src in stop", int'(core_src_o), 0);
    pulse_exit();
    chk("R8", "osc after exit", int'(osc_en_o), 1);
    chk("R8", "src held", int'(core_src_o), 0);
    tick(); tick();
    chk("R8", "src held no stable", int'(core_src_o), 0);
    osc_stable_i = 1'b1; tick(); osc_stable_i = 1'b0;
    chk("R8", "src pll after stable", int'(core_src_o), 1);
  endtask

  task automatic t_stop_lps();
    wr(8'h05);
    pulse_enter();
    chk("R7", "osc gated", int'(osc_en_o), 0);
    wr(8'h01);
    chk("R7", "lps rewrite ignored", int'(osc_en_o), 0);
    pulse_enter();
    chk("R11", "enter in stop ignored", int'(osc_en_o), 0);
    pulse_exit();
    chk("R8", "osc back", int'(osc_en_o), 1);
    chk("R8", "src osc wake", int'(core_src_o), 0);
    osc_stable_i = 1'b1; tick(); osc_stable_i = 1'b0;
    chk("R8", "src pll", int'(core_src_o), 1);
  endtask

  task automatic t_strobes_ignored();
    wr(8'h05);
    pulse_exit();
    chk("R11", "exit in run osc", int'(osc_en_o), 1);
    chk("R11", "exit in run src", int'(core_src_o), 1);
    pulse_enter();
    pulse_exit();
    pulse_enter();
    chk("R11", "enter in wake osc", int'(osc_en_o), 1);
    chk("R11", "enter in wake src", int'(core_src_o), 0);
    osc_stable_i = 1'b1; tick(); osc_stable_i = 1'b0;
    chk("R11", "run after wake", int'(core_src_o), 1);
    chk("R11", "osc after wake", int'(osc_en_o), 1);
    wr(8'h00);
  endtask

  task automatic t_clkout();
    wr(8'h00);
    for (int r = 0; r < 4; r++) begin
      clkout_req_i = 2'(r); #1;
      chk("R9", "sel test=0", int'(clkout_sel_o), (r == 2) ? 3 : r);
    end
    wr(8'h08);
    for (int r = 0; r < 4; r++) begin
      clkout_req_i = 2'(r); #1;
      chk("R9", "sel test=1", int'(clkout_sel_o), r);
    end
    clkout_req_i = 2'd0;
  endtask

  task automatic t_reset_again();
    wr(8'h03);
    chk("R5", "err before reset", int'(cfg_err_o), 1);
    rst_ni = 1'b0; #1;
    chk("R1", "err cleared", int'(cfg_err_o), 0);
    chk("R1", "rd cleared", int'(rd_data_o), 0);
    tick(); rst_ni = 1'b1; tick();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_modes();
    t_reserved();
    t_readback();
    t_stop_keep_osc();
    t_stop_lps();
    t_strobes_ignored();
    t_clkout();
    t_reset_again();
    finish_up();
  end
endmodule